// File: doc/BRIEF.md
# Distributed Fixed-Priority Bus Arbitration Node

This block is one station of a bus arbiter that has no central decision point. Each bus master carries its own copy of the node. Every node drives a single request line and reads the full vector of request lines from all nodes. From that shared vector, each node decides on its own whether it owns the bus. Priority is fixed by the node index, and the highest index wins.

All nodes leave reset together and watch the same registered vector, so each one can run an identical model of the bus: idle, or held by a known owner. An owner takes the bus only while that model says the bus is idle. Because every node reaches the same verdict, two owners never appear at once. An owner keeps its request line up until its local done pulse. It then drops both the request and ownership.

A fairness rule prevents starvation. When a node releases the bus, it records which lower-index nodes were requesting at that moment. It does not raise its request again until each of those nodes has owned the bus and then dropped its request. To build a complete arbiter, instantiate one node per master with a distinct index and feed the concatenated request outputs back to every node.

Top module: `dist_arb_node`

## Requirements
- R1: While reset is high, and on the first cycle after it, `req_o` and `own_o` are 0.
- R2: When `want_i` is 1, the node holds no request and is not locked out, `req_o` becomes 1 at the next clock edge.
- R3: When the bus is idle and at least one request line is set, the node whose index is the highest set bit of `req_bus_i` gets `own_o` = 1 at the next edge. A node asserting `req_o` while the bus is idle owns the bus one edge after its request appears.
- R4: Across all connected nodes, at most one `own_o` is 1 in any cycle.
- R5: An owner keeps `req_o` and `own_o` at 1 until it samples `done_i` = 1. At that edge both fall to 0.
- R6: After a release, the node keeps `req_o` at 0 until every lower-index node that was requesting at the release edge has owned the bus and then cleared its request.
- R7: A request from a higher-index node does not take the bus from the current owner. Ownership and the owner's identity stay unchanged while the owner's request line is high.
- R8: After the owner drops its request line, the bus stays idle for one cycle. Arbitration then picks the highest-index requester.
- R9: `done_i` has no effect on a node that is requesting but does not own the bus.
- R10: Only lower-index requesters are recorded at a release. If only higher-index nodes are requesting, the releasing node may request again at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, applied to all nodes together |
| want_i | input | 1 | Local master wishes to use the bus |
| done_i | input | 1 | Owner has finished its transfer; releases the bus |
| req_bus_i | input | NODES | Request lines of all nodes, bit k from node k |
| req_o | output | 1 | This node's request line |
| own_o | output | 1 | This node currently owns the bus |

## Verification
The assertions assume that bit IDX of `req_bus_i` is this node's own `req_o`. They also assume that every node sees the same vector in the same cycle and leaves reset on the same edge. Finally, they assume `done_i` is pulsed only to finish a tenure, with no other masters stepping outside the request protocol. The bench meets these assumptions by wiring four nodes to a single shared vector built from their outputs and by pulsing `done_i` for one cycle. One pulse is deliberately given to a non-owner to exercise R9. Scenarios cover a lone requester, contention with preemption attempts, a full lockout round, and a release with only higher-index requesters waiting.

// File: rtl/arb_node_pkg.sv
package arb_node_pkg;
  typedef enum logic {
    BUS_IDLE = 1'b0,
    BUS_HELD = 1'b1
  } bus_state_t;
endpackage

// File: rtl/arb_bus_tracker.sv
// Replicated bus model: every node runs this identically from the shared vector.
module arb_bus_tracker
  import arb_node_pkg::*;
#(
  parameter int NODES = 4,
  parameter int IW    = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] req_bus_i,
  output logic             grant_o,
  output logic [IW-1:0]    grant_idx_o,
  output logic             retire_o,
  output logic [IW-1:0]    retire_idx_o
);
  bus_state_t    state_q;
  logic [IW-1:0] owner_q;
  logic [IW-1:0] top_idx;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NODES; i++) begin
      if (req_bus_i[i]) top_idx = IW'(i);
    end
  end

  assign grant_o      = (state_q == BUS_IDLE) && (|req_bus_i);
  assign grant_idx_o  = top_idx;
  assign retire_o     = (state_q == BUS_HELD) && !req_bus_i[owner_q];
  assign retire_idx_o = owner_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_IDLE;
      owner_q <= '0;
    end else if (grant_o) begin
      state_q <= BUS_HELD;
      owner_q <= top_idx;
    end else if (retire_o) begin
      state_q <= BUS_IDLE;
    end
  end

  // R7: a held bus with its owner still requesting keeps the same owner
  a_r7_no_preempt: assert property (@(posedge clk) disable iff (rst)
    (state_q == BUS_HELD && req_bus_i[owner_q]) |=> (state_q == BUS_HELD && $stable(owner_q)));
endmodule

// File: rtl/arb_lockout.sv
// Honour rule: remembers lower-index requesters pending at release.
module arb_lockout #(
  parameter int NODES = 4,
  parameter int IDX   = 0,
  parameter int IW    = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             release_i,
  input  logic [NODES-1:0] req_bus_i,
  input  logic             retire_i,
  input  logic [IW-1:0]    retire_idx_i,
  output logic             locked_o
);
  localparam logic [NODES-1:0] LOWER = NODES'((64'd1 << IDX) - 64'd1);

  logic [NODES-1:0] pend_q;
  logic [NODES-1:0] retire_mask;

  always_comb begin
    retire_mask = '0;
    if (retire_i) retire_mask[retire_idx_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (release_i) begin
      pend_q <= req_bus_i & LOWER;
    end else begin
      pend_q <= pend_q & ~retire_mask;
    end
  end

  assign locked_o = |pend_q;

  // R6: between releases the pending set only loses members
  a_r6_pend_shrinks: assert property (@(posedge clk) disable iff (rst)
    !release_i |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/dist_arb_node.sv
module dist_arb_node #(
  parameter int NODES = 4,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_i,
  input  logic             done_i,
  input  logic [NODES-1:0] req_bus_i,
  output logic             req_o,
  output logic             own_o
);
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1;

  logic          req_q, own_q;
  logic          grant, retire, locked, release_now;
  logic [IW-1:0] grant_idx, retire_idx;

  arb_bus_tracker #(.NODES(NODES), .IW(IW)) u_track (
    .clk         (clk),
    .rst         (rst),
    .req_bus_i   (req_bus_i),
    .grant_o     (grant),
    .grant_idx_o (grant_idx),
    .retire_o    (retire),
    .retire_idx_o(retire_idx)
  );

  assign release_now = own_q && done_i;

  arb_lockout #(.NODES(NODES), .IDX(IDX), .IW(IW)) u_lock (
    .clk         (clk),
    .rst         (rst),
    .release_i   (release_now),
    .req_bus_i   (req_bus_i),
    .retire_i    (retire),
    .retire_idx_i(retire_idx),
    .locked_o    (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      own_q <= 1'b0;
    end else begin
      if (release_now) begin
        req_q <= 1'b0;
        own_q <= 1'b0;
      end else begin
        if (!req_q && want_i && !locked) req_q <= 1'b1;
        if (grant && grant_idx == IW'(IDX)) own_q <= 1'b1;
      end
    end
  end

  assign req_o = req_q;
  assign own_o = own_q;

  // R5: an owner keeps its request line up
  a_r5_owner_requests: assert property (@(posedge clk) disable iff (rst)
    own_q |-> req_q);
  // R5: done on an owner clears request and ownership together
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (own_q && done_i) |=> (!own_q && !req_q));
  // R3: ownership is only taken by a node whose line was visible on the bus
  a_r3_grant_visible: assert property (@(posedge clk) disable iff (rst)
    $rose(own_q) |-> $past(req_bus_i[IDX]));
  // R6: no request is raised while locked out
  a_r6_no_raise_locked: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> !$past(locked));
endmodule

// File: tb/dist_arb_node_test.sv
module dist_arb_node_test;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] want = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] req;
  logic [N-1:0] own;

  int checks = 0;
  int fails = 0;
  int multi_owner = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_node
    dist_arb_node #(.NODES(N), .IDX(g)) uut (
      .clk(clk), .rst(rst), .want_i(want[g]), .done_i(done[g]),
      .req_bus_i(req), .req_o(req[g]), .own_o(own[g])
    );
  end

  always @(negedge clk) if (!rst && $countones(own) > 1) multi_owner++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_owner(input int k, input string tag);
    bit found = 1'b0;
    for (int i = 0; i < 40 && !found; i++) begin
      if (own[k]) found = 1'b1;
      else step(1);
    end
    chk(own[k] === 1'b1, tag, own, 32'(1 << k));
  endtask

  task automatic release_bus(input int k, input bit keep_want);
    done[k] = 1'b1;
    want[k] = keep_want;
    step(1);
    chk(own[k] === 1'b0 && req[k] === 1'b0, "R5 release clears own/req", {own[k], req[k]}, 0);
    done[k] = 1'b0;
  endtask

  task automatic t_reset();
    chk(req === '0 && own === '0, "R1 outputs low in reset", {req, own}, 0);
    @(negedge clk);
    rst = 1'b0;
    step(1);
    chk(req === '0 && own === '0, "R1 outputs low after reset", {req, own}, 0);
  endtask

  task automatic t_basic();
    want[2] = 1'b1;
    step(1);
    chk(req === 4'b0100, "R2 request raised next edge", req, 4'b0100);
    chk(own === '0, "R3 not owned before arbitration", own, 0);
    step(1);
    chk(own === 4'b0100, "R3 lone requester granted", own, 4'b0100);
    want[3] = 1'b1;
    step(3);
    chk(own === 4'b0100 && req[2] === 1'b1, "R7 higher request no preempt", own, 4'b0100);
    chk(req[3] === 1'b1, "R2 waiting node raised request", req[3], 1);
    release_bus(2, 1'b0);
    step(1);
    chk(own === '0, "R8 idle cycle after release", own, 0);
    step(1);
    chk(own === 4'b1000, "R8 rearbitration grants waiting node", own, 4'b1000);
    release_bus(3, 1'b0);
    step(3);
  endtask

  task automatic t_lockout();
    want[0] = 1'b1; want[1] = 1'b1; want[3] = 1'b1;
    wait_owner(3, "R3 highest of three wins");
    release_bus(3, 1'b1);
    wait_owner(1, "R8 next highest after release");
    chk(req[3] === 1'b0, "R6 locked while lower waits", req[3], 0);
    release_bus(1, 1'b0);
    wait_owner(0, "R6 lowest served before relock ends");
    chk(req[3] === 1'b0, "R6 still locked while node0 owns", req[3], 0);
    release_bus(0, 1'b0);
    wait_owner(3, "R6 lockout lifted after lower served");
    release_bus(3, 1'b0);
    step(3);
  endtask

  task automatic t_higher_only();
    want[1] = 1'b1;
    wait_owner(1, "R3 node1 granted");
    want[3] = 1'b1;
    step(2);
    release_bus(1, 1'b1);
    step(1);
    chk(req[1] === 1'b1, "R10 higher requester does not lock", req[1], 1);
    wait_owner(3, "R10 higher node wins after release");
    chk(own[1] === 1'b0, "R4 node1 not co-owner", own[1], 0);
    release_bus(3, 1'b0);
    wait_owner(1, "R10 node1 served again");
    release_bus(1, 1'b0);
    step(3);
  endtask

  task automatic t_done_ignored();
    want[3] = 1'b1;
    wait_owner(3, "R3 node3 granted");
    want[2] = 1'b1;
    step(2);
    done[2] = 1'b1;
    step(1);
    chk(req[2] === 1'b1 && own[2] === 1'b0, "R9 done on non-owner ignored", {req[2], own[2]}, 2'b10);
    done[2] = 1'b0;
    release_bus(3, 1'b0);
    wait_owner(2, "R9 node2 still served later");
    release_bus(2, 1'b0);
    step(3);
  endtask

  initial begin
    step(3);
    t_reset();
    t_basic();
    t_lockout();
    t_higher_only();
    t_done_ignored();
    chk(multi_owner == 0, "R4 never two owners", multi_owner, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule